// File: doc/BRIEF.md
# Serial 1101 Pattern Detector with Moore and Mealy Outputs

This block watches a one-bit serial stream. It samples the stream on every rising clock edge and flags each place where the four most recent bits, oldest first, read 1, 1, 0, 1. Matches may overlap, so the final 1 of one match can be the first 1 of the next. The same detection is built twice, and each copy has its own output.

- A five-state machine whose output depends only on its state. Its flag rises in the cycle after the completing bit has been clocked in.
- A four-state machine whose output depends on its state and on the live input. Its flag rises within the cycle that carries the completing bit.

A flip-flop copy of the second flag is also provided. It changes only on clock edges.

An active-high asynchronous clear returns both machines to idle and discards any partial match. A parameter chooses between binary and one-hot encoding of the five-state machine's register. The encoding has no effect on the port behaviour.

Top module: `seqdet_dual`

## Requirements
- R1: While `clr` is 1, all three outputs are 0 whatever `din` is. Raising `clr` between clock edges drops `det_moore` and `det_mealy_q` at once, without waiting for a clock.
- R2: `det_mealy` is 1 exactly when the present `din` is 1 and the three bits sampled before it since the last clear were 1, 1, 0, oldest first. It follows `din` within the same cycle.
- R3: Matches overlap: the stream 1,1,0,1,1,0,1 gives two `det_mealy` pulses, on the 4th and 7th bits.
- R4: A run of more than two 1s followed by 0,1 still matches: 1,1,1,0,1 pulses on its last bit.
- R5: A 0 after the partial match 1,1,0 discards it: 1,1,0,0,1 gives no pulse.
- R6: `det_moore` is 1 for exactly the one clock cycle after each cycle in which `det_mealy` was 1 at the sampling edge, and otherwise 0.
- R7: `det_mealy_q` is `det_mealy` as sampled at the previous rising edge, so it equals `det_moore` in every cycle.
- R8: Binary and one-hot encoding of the five-state register (`MOORE_ONEHOT` = 0 or 1) give identical port behaviour.
- R9: Bits sampled before a clear never count toward a match after it: 1,1,0, then clear, then 1 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| din | input | 1 | Serial input bit |
| det_moore | output | 1 | Match flag decoded from state only |
| det_mealy | output | 1 | Match flag from state and live input |
| det_mealy_q | output | 1 | Registered copy of `det_mealy` |

## Verification
A wrong state in the four-state machine shows up at `det_mealy` on the first cycle whose input bit exposes it. For example, a machine left in the "seen 1,1,0" state flags a lone 1, and a machine that failed to advance misses a match in that same cycle. A wrong state in the five-state machine shows up one cycle later, as `det_moore` disagreeing with `det_mealy_q`. Because the two machines are built separately, any drift between them surfaces within one clock of the bit that triggers it. Clearing the block mid-match makes stale history visible on the next 1.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

   localparam int MOORE_NSTATES = 5;
   localparam int MEALY_NSTATES = 4;
   localparam int MOORE_SW      = $clog2(MOORE_NSTATES);
   localparam int MEALY_SW      = $clog2(MEALY_NSTATES);

   // history-named states: what part of 1,1,0,1 has been seen
   typedef enum logic [MOORE_SW-1:0] {
      MO_NONE = 3'd0,
      MO_ONE  = 3'd1,
      MO_ONE2 = 3'd2,
      MO_ZERO = 3'd3,
      MO_HIT  = 3'd4
   } moore_st_t;

   typedef enum logic [MEALY_SW-1:0] {
      ME_NONE = 2'd0,
      ME_ONE  = 2'd1,
      ME_ONE2 = 2'd2,
      ME_ZERO = 2'd3
   } mealy_st_t;

endpackage

// File: rtl/seqdet_moore.sv
module seqdet_moore
   import seqdet_pkg::*;
#(
   parameter int MOORE_ONEHOT = 0
) (
   input  logic clk,
   input  logic clr,
   input  logic din,
   output logic det
);

   if (MOORE_ONEHOT != 0 && MOORE_ONEHOT != 1) begin : g_bad_enc
      $error("seqdet_moore: MOORE_ONEHOT must be 0 or 1");
   end

   if (MOORE_ONEHOT == 1) begin : g_onehot
      logic [MOORE_NSTATES-1:0] oh_q, oh_d;

      always_comb begin
         oh_d[MO_NONE] = (oh_q[MO_NONE] | oh_q[MO_ONE] | oh_q[MO_ZERO] | oh_q[MO_HIT]) & ~din;
         oh_d[MO_ONE]  = oh_q[MO_NONE] & din;
         oh_d[MO_ONE2] = (oh_q[MO_ONE] | oh_q[MO_ONE2] | oh_q[MO_HIT]) & din;
         oh_d[MO_ZERO] = oh_q[MO_ONE2] & ~din;
         oh_d[MO_HIT]  = oh_q[MO_ZERO] & din;
      end

      always_ff @(posedge clk or posedge clr) begin
         if (clr) oh_q <= MOORE_NSTATES'(1);
         else     oh_q <= oh_d;
      end

      assign det = oh_q[MO_HIT];

      // R8
      onehot_valid_chk: assert property (@(posedge clk) disable iff (clr)
         $countones(oh_q) == 1);
   end else begin : g_binary
      moore_st_t st_q, st_d;

      always_comb begin
         unique case (st_q)
            MO_NONE: st_d = din ? MO_ONE  : MO_NONE;
            MO_ONE:  st_d = din ? MO_ONE2 : MO_NONE;
            MO_ONE2: st_d = din ? MO_ONE2 : MO_ZERO;
            MO_ZERO: st_d = din ? MO_HIT  : MO_NONE;
            MO_HIT:  st_d = din ? MO_ONE2 : MO_NONE;
            default: st_d = MO_NONE;
         endcase
      end

      always_ff @(posedge clk or posedge clr) begin
         if (clr) st_q <= MO_NONE;
         else     st_q <= st_d;
      end

      assign det = (st_q == MO_HIT);

      // R8
      legal_state_chk: assert property (@(posedge clk) disable iff (clr)
         st_q <= MO_HIT);
   end

   // R6
   moore_single_chk: assert property (@(posedge clk) disable iff (clr)
      det |=> !det);

endmodule

// File: rtl/seqdet_mealy.sv
module seqdet_mealy
   import seqdet_pkg::*;
(
   input  logic clk,
   input  logic clr,
   input  logic din,
   output logic det,
   output logic det_q
);

   mealy_st_t st_q, st_d;

   always_comb begin
      det = 1'b0;
      unique case (st_q)
         ME_NONE: st_d = din ? ME_ONE  : ME_NONE;
         ME_ONE:  st_d = din ? ME_ONE2 : ME_NONE;
         ME_ONE2: st_d = din ? ME_ONE2 : ME_ZERO;
         ME_ZERO: begin
            st_d = din ? ME_ONE : ME_NONE;
            det  = din;
         end
         default: st_d = ME_NONE;
      endcase
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) st_q <= ME_NONE;
      else     st_q <= st_d;
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) det_q <= 1'b0;
      else     det_q <= det;
   end

   // R3
   hit_resume_chk: assert property (@(posedge clk) disable iff (clr)
      det |=> (st_q == ME_ONE));

endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
   import seqdet_pkg::*;
#(
   parameter int MOORE_ONEHOT = 0
) (
   input  logic clk,
   input  logic clr,
   input  logic din,
   output logic det_moore,
   output logic det_mealy,
   output logic det_mealy_q
);

   seqdet_moore #(.MOORE_ONEHOT(MOORE_ONEHOT)) moore_i (
      .clk (clk),
      .clr (clr),
      .din (din),
      .det (det_moore)
   );

   seqdet_mealy mealy_i (
      .clk   (clk),
      .clr   (clr),
      .din   (din),
      .det   (det_mealy),
      .det_q (det_mealy_q)
   );

   // R6
   moore_follows_chk: assert property (@(posedge clk) disable iff (clr)
      det_mealy |=> det_moore);

   // R6
   moore_cause_chk: assert property (@(posedge clk) disable iff (clr)
      det_moore |-> $past(det_mealy));

   // R7
   reg_copy_match_chk: assert property (@(posedge clk) disable iff (clr)
      det_mealy_q == det_moore);

endmodule

// File: tb/seqdet_dual_tb_top.sv
module seqdet_dual_tb_top;

   logic clk = 1'b0;
   logic clr = 1'b1;
   logic din = 1'b0;
   logic mo_b, me_b, mq_b;
   logic mo_h, me_h, mq_h;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [2:0] hist;
   int         hcnt;
   logic       prev_exp;

   always #10 clk = ~clk;

   seqdet_dual #(.MOORE_ONEHOT(0)) dut_i (
      .clk(clk), .clr(clr), .din(din),
      .det_moore(mo_b), .det_mealy(me_b), .det_mealy_q(mq_b));

   seqdet_dual #(.MOORE_ONEHOT(1)) dut_oh_i (
      .clk(clk), .clr(clr), .din(din),
      .det_moore(mo_h), .det_mealy(me_h), .det_mealy_q(mq_h));

   // {din, expected det_mealy}; covers R3 (idx 6), R4 (idx 12), R5 (idx 18)
   localparam int NV = 24;
   localparam logic [1:0] VEC [0:NV-1] = '{
      2'b10, 2'b10, 2'b00, 2'b11, 2'b10, 2'b00, 2'b11, 2'b00,
      2'b10, 2'b10, 2'b10, 2'b00, 2'b11, 2'b00, 2'b00, 2'b10,
      2'b10, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 2'b11, 2'b10
   };

   task automatic chk(input string req, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      hist = 3'b000; hcnt = 0; prev_exp = 1'b0;
   endtask

   // drive one bit at the falling edge, check, then let the rising edge take it
   task automatic step(input logic b, input logic use_tbl, input logic tbl_exp,
                       input string req);
      logic e;
      @(negedge clk);
      din = b;
      #2;
      e = (hcnt >= 3) && ({hist, b} == 4'b1101);
      if (use_tbl) e = tbl_exp;
      chk({req, " R2 mealy bin"}, me_b, e);
      chk({req, " R8 mealy onehot"}, me_h, e);
      chk({req, " R6 moore bin"}, mo_b, prev_exp);
      chk({req, " R8 moore onehot"}, mo_h, prev_exp);
      chk({req, " R7 mealy_q"}, mq_b, prev_exp);
      chk({req, " R7 mealy_q onehot"}, mq_h, prev_exp);
      @(posedge clk);
      #1;
      prev_exp = e;
      hist = {hist[1:0], b};
      if (hcnt < 3) hcnt++;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] lfsr;
      model_clear();
      // R1: outputs low while clear is held, even with din high
      clr = 1'b1;
      din = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #2;
      chk("R1 reset moore", mo_b, 1'b0);
      chk("R1 reset mealy", me_b, 1'b0);
      chk("R1 reset mealy_q", mq_b, 1'b0);
      clr = 1'b0;
      din = 1'b0;

      // table walk (R2, R3, R4, R5)
      for (int i = 0; i < NV; i++)
         step(VEC[i][1], 1'b1, VEC[i][0], "R3 R4 R5 table");

      // R1: asynchronous clear while det_moore is high
      model_clear();
      clr = 1'b1;
      @(posedge clk); #1;
      clr = 1'b0;
      step(1, 0, 0, "R2"); step(1, 0, 0, "R2"); step(0, 0, 0, "R2"); step(1, 0, 0, "R2");
      @(negedge clk);
      #2;
      chk("R6 moore high before clear", mo_b, 1'b1);
      clr = 1'b1;
      #2;
      chk("R1 async moore drop", mo_b, 1'b0);
      chk("R1 async moore drop onehot", mo_h, 1'b0);
      chk("R1 async mealy_q drop", mq_b, 1'b0);
      @(negedge clk);
      clr = 1'b0;
      model_clear();

      // R9: history before clear is forgotten
      step(1, 0, 0, "R9"); step(1, 0, 0, "R9"); step(0, 0, 0, "R9");
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      model_clear();
      step(1, 1, 0, "R9 stale history");
      step(1, 1, 0, "R9");
      step(0, 1, 0, "R9");
      step(1, 1, 1, "R9 fresh match");

      // random stream against the sliding-window model (R2, R6, R7, R8)
      lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[3], 0, 0, "R2 random");
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule